// File: doc/BRIEF.md
# Lockable Standby GPIO Port Register Bank

This block holds the host-visible registers of a small standby I/O port with six bidirectional pins and two input-only pins. A byte-wide register interface (address, write strobe, read strobe, write data, read data) reaches two registers. One is a data-out register, and its low six bits drive the bidirectional pins whose output enables are set. The other is a read-only data-in register that shows all eight pin levels after synchronization.

Protection comes from two inputs supplied by the surrounding configuration logic. A per-pin lock vector freezes the matching data-out bits against host writes. A global lock stops both the power-up reset and the software reset from reloading the data-out register, so a port that was set up before a reset keeps driving the same levels. The output-enable vector comes from configuration logic outside this block.

Top module: `gpio_lock_bank`

## Requirements
- R1: When `rst_ni` is low or `sw_rst_i` is high at a rising clock edge while `glb_lock_i` is 0, the data-out register loads 3Fh.
- R2: When `glb_lock_i` is 1, a power-up reset (`rst_ni` low) or a software reset (`sw_rst_i` high) leaves the data-out register unchanged, and host writes during that reset are also discarded.
- R3: A write to offset 08h copies write-data bit i into data-out bit i for each i in 0..5 whose `pin_lock_i[i]` is 0. Bits whose lock is 1 keep their old value.
- R4: Data-out bits 7 and 6 do not exist. They read as 0, and write data in those positions is discarded.
- R5: A read of offset 08h returns the latched data-out value in bits 5..0, whatever the pin levels and the output enables are.
- R6: A read of offset 09h returns `{inonly_i[1:0], bidir_in_i[5:0]}` (bit 7 = input-only pin 1, bit 0 = bidirectional pin 0) after a two-flop synchronizer. A level applied before rising edge n is returned by a read strobed at edge n+2 or later. A read strobed at edge n+1 still returns the previous level.
- R7: Writes to offset 09h have no effect on any register.
- R8: `bidir_oe_o` follows `oe_cfg_i`. `bidir_out_o[i]` equals data-out bit i while `oe_cfg_i[i]` is 1 and is 0 (pin released) while it is 0.
- R9: A read of any offset other than 08h and 09h returns 00h. A write to such an offset changes nothing.
- R10: `rdata_o` is registered. It takes the addressed value at the rising edge where `rd_i` is 1, holds its value on every other edge, and is 00h after `rst_ni` reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, active low, synchronous |
| sw_rst_i | input | 1 | Software reset request, active high |
| glb_lock_i | input | 1 | Global lock; blocks reset of the data-out register |
| pin_lock_i | input | 6 | Per-pin write lock for data-out bits |
| addr_i | input | 8 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| oe_cfg_i | input | 6 | Output-enable configuration per bidirectional pin |
| bidir_in_i | input | 6 | Levels seen on the bidirectional pins |
| inonly_i | input | 2 | Levels seen on the input-only pins |
| bidir_out_o | output | 6 | Drive value to the bidirectional pads |
| bidir_oe_o | output | 6 | Drive enable to the bidirectional pads |

## Verification
The properties assume that `glb_lock_i` is 0 during the first power-up reset, because otherwise the data-out register never gets a defined value. They also assume that `rd_i` and `wr_i` are never high in the same cycle as each other at one offset they could conflict on. The bench opens with an unlocked reset and changes every strobe, address and lock at the falling edge, one operation at a time. It moves pin levels only when a read is not in progress, except in the single sequence that measures synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register selected by the current host address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DOUT = 2'd1,
        SEL_DIN  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/gpio_dout_reg.sv
module gpio_dout_reg #(
    parameter int              N_IO    = 6,
    parameter logic [N_IO-1:0] RST_VAL = '1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sw_rst_i,
    input  logic            glb_lock_i,
    input  logic [N_IO-1:0] pin_lock_i,
    input  logic            wr_en_i,
    input  logic [N_IO-1:0] wdata_i,
    output logic [N_IO-1:0] dout_o
);

    typedef struct packed {
        logic [N_IO-1:0] bits;
    } dout_st_t;

    dout_st_t        st_d, st_q;
    logic [N_IO-1:0] merged;
    logic            any_rst;

    // Per-bit merge: a locked bit keeps its stored value
    for (genvar i = 0; i < N_IO; i++) begin : g_bit
        assign merged[i] = pin_lock_i[i] ? st_q.bits[i] : wdata_i[i];
    end

    assign any_rst = !rst_ni || sw_rst_i;

    // Reset is folded into the next-state logic so the global lock can veto it
    always_comb begin
        st_d = st_q;
        if (any_rst) begin
            if (!glb_lock_i) begin
                st_d.bits = RST_VAL;
            end
        end else if (wr_en_i) begin
            st_d.bits = merged;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign dout_o = st_q.bits;

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
    import gpio_bank_pkg::*;
#(
    parameter int DW   = 8,
    parameter int N_IO = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_i,
    input  reg_sel_e        sel_i,
    input  logic [N_IO-1:0] dout_i,
    input  logic [DW-1:0]   din_i,
    output logic [DW-1:0]   rdata_o
);

    localparam int PAD_W = DW - N_IO;

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            unique case (sel_i)
                SEL_DOUT: st_d.data = {{PAD_W{1'b0}}, dout_i};
                SEL_DIN:  st_d.data = din_i;
                default:  st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.data;

endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
    import gpio_bank_pkg::*;
#(
    parameter int                N_IO        = 6,
    parameter int                N_IN        = 2,
    parameter int                ADDR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DOUT_OFS    = 8'h08,
    parameter logic [ADDR_W-1:0] DIN_OFS     = 8'h09,
    parameter logic [N_IO-1:0]   DOUT_RST    = 6'h3F
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_rst_i,
    input  logic              glb_lock_i,
    input  logic [N_IO-1:0]   pin_lock_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [N_IO-1:0]   oe_cfg_i,
    input  logic [N_IO-1:0]   bidir_in_i,
    input  logic [N_IN-1:0]   inonly_i,
    output logic [N_IO-1:0]   bidir_out_o,
    output logic [N_IO-1:0]   bidir_oe_o
);

    localparam int DW = N_IO + N_IN;

    reg_sel_e        sel;
    logic            wr_dout;
    logic [N_IO-1:0] dout_w;
    logic [DW-1:0]   din_raw;
    logic [DW-1:0]   din_sync;
    logic [DW-1:0]   rdata_w;
    logic            unused_wdata_hi;

    // Address decode
    always_comb begin
        sel = SEL_NONE;
        if (addr_i == DOUT_OFS) begin
            sel = SEL_DOUT;
        end else if (addr_i == DIN_OFS) begin
            sel = SEL_DIN;
        end
    end

    assign wr_dout         = wr_i && (sel == SEL_DOUT);
    assign unused_wdata_hi = ^wdata_i[7:N_IO];
    assign din_raw         = {inonly_i, bidir_in_i};

    gpio_pin_sync #(
        .W      (DW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (din_raw),
        .sync_o  (din_sync)
    );

    gpio_dout_reg #(
        .N_IO    (N_IO),
        .RST_VAL (DOUT_RST)
    ) u_dout (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_rst_i   (sw_rst_i),
        .glb_lock_i (glb_lock_i),
        .pin_lock_i (pin_lock_i),
        .wr_en_i    (wr_dout),
        .wdata_i    (wdata_i[N_IO-1:0]),
        .dout_o     (dout_w)
    );

    gpio_rd_port #(
        .DW   (DW),
        .N_IO (N_IO)
    ) u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (rd_i),
        .sel_i   (sel),
        .dout_i  (dout_w),
        .din_i   (din_sync),
        .rdata_o (rdata_w)
    );

    assign rdata_o     = rdata_w;
    assign bidir_oe_o  = oe_cfg_i;
    assign bidir_out_o = dout_w & oe_cfg_i;

endmodule

// File: rtl/gpio_lock_bank_chk.sv
module gpio_lock_bank_chk #(
    parameter int                N_IO     = 6,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DOUT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] DIN_OFS  = 8'h09,
    parameter logic [N_IO-1:0]   DOUT_RST = 6'h3F
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sw_rst_i,
    input logic              glb_lock_i,
    input logic [N_IO-1:0]   pin_lock_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic [N_IO-1:0]   oe_cfg_i,
    input logic [N_IO-1:0]   bidir_out_o,
    input logic [N_IO-1:0]   bidir_oe_o,
    input logic [N_IO-1:0]   dout_w
);

    AST_SWRST_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_rst_i && !glb_lock_i) |=> (dout_w == DOUT_RST)); // R1

    AST_LOCK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_rst_i && glb_lock_i) |=> $stable(dout_w)); // R2

    AST_LOCKED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !sw_rst_i) |=> (((dout_w ^ $past(dout_w)) & $past(pin_lock_i)) == '0)); // R3

    AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !sw_rst_i && addr_i == DOUT_OFS)
        |=> ((dout_w & ~$past(pin_lock_i)) == ($past(wdata_i[N_IO-1:0]) & ~$past(pin_lock_i)))); // R3

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == DOUT_OFS) |=> (rdata_o[7:N_IO] == '0)); // R4

    AST_OTHER_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !sw_rst_i && addr_i != DOUT_OFS) |=> $stable(dout_w)); // R7

    AST_PIN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bidir_out_o & ~bidir_oe_o) == '0) && (bidir_oe_o == oe_cfg_i)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i != DOUT_OFS && addr_i != DIN_OFS) |=> (rdata_o == 8'h00)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o)); // R10

endmodule

bind gpio_lock_bank gpio_lock_bank_chk #(
    .N_IO     (N_IO),
    .ADDR_W   (ADDR_W),
    .DOUT_OFS (DOUT_OFS),
    .DIN_OFS  (DIN_OFS),
    .DOUT_RST (DOUT_RST)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_rst_i    (sw_rst_i),
    .glb_lock_i  (glb_lock_i),
    .pin_lock_i  (pin_lock_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .oe_cfg_i    (oe_cfg_i),
    .bidir_out_o (bidir_out_o),
    .bidir_oe_o  (bidir_oe_o),
    .dout_w      (dout_w)
);

// File: tb/gpio_lock_bank_tb.sv
`timescale 1ns/1ps
module gpio_lock_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       glb_lock = 1'b0;
    logic [5:0] pin_lock = '0;
    logic [7:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] oe_cfg = '0;
    logic [5:0] bidir_in = 6'h15;
    logic [1:0] inonly = 2'b01;
    logic [5:0] bidir_out;
    logic [5:0] bidir_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic rd_seen = 1'b0;
    bit   done = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2 clk = ~clk;

    gpio_lock_bank dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sw_rst_i    (sw_rst),
        .glb_lock_i  (glb_lock),
        .pin_lock_i  (pin_lock),
        .addr_i      (addr),
        .wr_i        (wr),
        .rd_i        (rd),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .oe_cfg_i    (oe_cfg),
        .bidir_in_i  (bidir_in),
        .inonly_i    (inonly),
        .bidir_out_o (bidir_out),
        .bidir_oe_o  (bidir_oe)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Driver: one write strobe, launched at a falling edge
    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    // Driver: one read strobe; expected item goes to the scoreboard
    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        rd   = 1'b1;
        exp_q.push_back(exp);
        req_q.push_back(req);
        @(negedge clk);
        rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: rdata is valid one falling edge after the strobed rising edge
    always @(posedge clk) rd_seen <= rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R10: actual %02h expected none (empty scoreboard)", rdata);
            end else begin
                check(rdata, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        check(rdata, 8'h00, "R10 reset value");
        do_read(8'h08, 8'h3F, "R1 power-up value");
        do_read(8'h09, 8'h55, "R6 pins after reset");
        do_read(8'h20, 8'h00, "R9 unmapped read");

        // Writes and reserved bits
        do_write(8'h08, 8'hFF);
        do_read(8'h08, 8'h3F, "R4 reserved bits read zero");
        do_write(8'h08, 8'h15);
        do_read(8'h08, 8'h15, "R3 unlocked write");
        do_write(8'h08, 8'hC0);
        do_read(8'h08, 8'h00, "R4 reserved write discarded");
        do_write(8'h08, 8'h15);

        // Per-pin lock
        pin_lock = 6'b000011;
        do_write(8'h08, 8'h00);
        do_read(8'h08, 8'h01, "R3 locked bits kept");
        do_write(8'h08, 8'h2E);
        do_read(8'h08, 8'h2D, "R3 partial lock merge");
        pin_lock = '0;

        // Pin drive gating
        @(negedge clk);
        oe_cfg = 6'b101010;
        @(negedge clk);
        check({2'b00, bidir_out}, 8'h28, "R8 drive under partial enable");
        check({2'b00, bidir_oe}, 8'h2A, "R8 enable follows config");
        oe_cfg = 6'h00;
        @(negedge clk);
        check({2'b00, bidir_out}, 8'h00, "R8 released pins");

        // Data-out read ignores pins; data-in shows pins
        oe_cfg   = 6'h3F;
        bidir_in = 6'h00;
        idle(3);
        do_read(8'h08, 8'h2D, "R5 latched value not pins");
        do_read(8'h09, 8'h40, "R6 pin levels");

        // Synchronizer latency
        @(negedge clk);
        bidir_in = 6'h3A;
        inonly   = 2'b10;
        do_read(8'h09, 8'h40, "R6 old level one edge later");
        do_read(8'h09, 8'hBA, "R6 new level two edges later");

        // Data-in is read-only
        do_write(8'h09, 8'h33);
        do_read(8'h08, 8'h2D, "R7 write to data-in leaves data-out");
        do_read(8'h09, 8'hBA, "R7 data-in still pins");

        // Unmapped writes and reads
        do_write(8'h10, 8'hFF);
        do_write(8'h07, 8'h00);
        do_read(8'h08, 8'h2D, "R9 unmapped writes ignored");
        do_read(8'h10, 8'h00, "R9 unmapped read zero");
        do_read(8'h0A, 8'h00, "R9 unmapped read next offset");

        // Read data holds without a strobe
        do_read(8'h08, 8'h2D, "R10 strobed read");
        @(negedge clk);
        bidir_in = 6'h07;
        addr     = 8'h09;
        idle(5);
        check(rdata, 8'h2D, "R10 holds without strobe");

        // Global lock suppresses resets
        glb_lock = 1'b1;
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        do_read(8'h08, 8'h2D, "R2 software reset under lock");
        @(negedge clk);
        sw_rst = 1'b1;
        addr   = 8'h08;
        wdata  = 8'h00;
        wr     = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        wr     = 1'b0;
        do_read(8'h08, 8'h2D, "R2 write during locked reset");
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        do_read(8'h08, 8'h2D, "R2 power-up reset under lock");
        glb_lock = 1'b0;
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        do_read(8'h08, 8'h3F, "R1 software reset unlocked");

        idle(3);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule